// File: doc/BRIEF.md
# MDIO Clause 45 Management Master

This block is the management-bus master that a host uses to read and write PHY registers over a two-wire MDIO/MDC link. The host presents one access at a time with a single-cycle request strobe. Along with the strobe it gives a write/read flag and a flag that picks Clause 45 or Clause 22 framing. It also gives a 5-bit PHY port address, a 5-bit device address, a 16-bit register address and 16-bit write data. When the whole bus transaction has finished, the block raises a one-cycle done pulse, with read data and an error flag valid on the same cycle.

MDC is derived from the system clock by a fixed divider: `HALF_DIV` system clocks low, then `HALF_DIV` high. MDIO is driven through an output, an output enable and an input, so that a pad or tri-state buffer outside the block closes the bus. A Clause 45 access is carried out as two back-to-back frames: an address frame that loads the register address, then the read or write frame. A Clause 22 access is a single frame, in which the device-address field carries the register number. On reads the turnaround is checked, and a PHY that does not answer is flushed and reported.

Top module: `mdio_master`

## Requirements
- R1: While reset is asserted, and after it is released with no request, MDC is low, the MDIO output enable is low and done is low.
- R2: Every frame opens with 32 bits of value 1 driven on MDIO.
- R3: Start and opcode bits follow the preamble, driven first bit first. Clause 45 frames use start 00, with opcode 00 for an address frame, 01 for a write and 11 for a read. Clause 22 frames use start 01, with opcode 01 for a write and 10 for a read.
- R4: After the opcode come the 5-bit port address and then the 5-bit device address (the register number under Clause 22), each most significant bit first.
- R5: In address and write frames the master drives the turnaround as 1 then 0, then 16 payload bits MSB first, then clocks one more bit with MDIO released.
- R6: A Clause 45 access is an address frame carrying the 16-bit register address, followed immediately by the data frame with the same port and device address. A Clause 22 access is the data frame alone.
- R7: In a read frame the master releases MDIO after the device address and clocks two turnaround bits. If the second one is 0, it shifts in 16 data bits MSB first, clocks one more released bit, and returns the data with the error flag at 0.
- R8: If the second turnaround bit of a read is 1, the master clocks 32 further released bits, then returns read data 0xFFFF with the error flag at 1.
- R9: MDC is high for exactly `HALF_DIV` system clocks and low for `HALF_DIV` within a transaction. MDIO data and output enable change only while MDC is low.
- R10: Read bits are sampled `SAMPLE_DLY` system clocks after the MDC rising edge. A PHY value that settles up to that delay after the edge is captured.
- R11: A request made while an access is in progress is ignored. The bus activity and the result of the running access are unchanged, and no extra done pulse is produced.
- R12: Done is high for exactly one system clock per accepted request. A write reports the error flag at 0, including a write that follows a failed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start-of-access strobe, sampled when idle |
| wr_i | input | 1 | 1 = write access, 0 = read access |
| c45_i | input | 1 | 1 = Clause 45 framing, 0 = Clause 22 |
| phy_i | input | 5 | PHY port address |
| dev_i | input | 5 | Device address (Clause 22: register number) |
| addr_i | input | 16 | Clause 45 register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid with done |
| err_o | output | 1 | Turnaround failure flag, valid with done |
| done_o | output | 1 | One-cycle completion pulse |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value from the pad |

## Verification
The bench builds the block with `HALF_DIV = 4` and `SAMPLE_DLY = 2`. An MDC bit then takes eight system clocks, so a full Clause 45 access with both frames fits in about a thousand cycles. That leaves room for the full opcode matrix, good and failed turnarounds and a request injected mid-access. The bench PHY settles its read bits 30 ns after each MDC rise. With the 40 ns sample delay this value is captured, while a sampler without the delay would see the previous bit. The bench therefore exposes any loss of the sample offset.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_TX, S_TA, S_RX, S_DRAIN, S_TAIL, S_DONE
  } mdio_state_e;

  localparam logic [1:0] ST_C45      = 2'b00;
  localparam logic [1:0] ST_C22      = 2'b01;
  localparam logic [1:0] OP_C45_ADDR = 2'b00;
  localparam logic [1:0] OP_C45_WR   = 2'b01;
  localparam logic [1:0] OP_C45_RD   = 2'b11;
  localparam logic [1:0] OP_C22_WR   = 2'b01;
  localparam logic [1:0] OP_C22_RD   = 2'b10;

  localparam int FRAME_W  = 64;
  localparam int RD_HDR_W = 46;  // preamble + start + op + port + dev
  localparam int DATA_W   = 16;
  localparam int DRAIN_W  = 32;

  function automatic logic [FRAME_W-1:0] mk_frame(input logic c45, input logic [1:0] op,
                                                  input logic [4:0] phy, input logic [4:0] dev,
                                                  input logic [15:0] pay);
    return {32'hFFFF_FFFF, (c45 ? ST_C45 : ST_C22), op, phy, dev, 2'b10, pay};
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_DIV   = 16,
  parameter int SAMPLE_DLY = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic sample_o,
  output logic bit_end_o
);
  localparam int PER = 2 * HALF_DIV;
  localparam int CW  = (PER > 2) ? $clog2(PER) : 1;
  localparam logic [CW-1:0] RISE_AT = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] LAST    = CW'(PER - 1);
  localparam logic [CW-1:0] SMP_AT  = CW'(HALF_DIV + SAMPLE_DLY);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      if (cnt_q == RISE_AT)   mdc_q <= 1'b1;
      else if (cnt_q == LAST) mdc_q <= 1'b0;
    end
  end

  assign mdc_o     = mdc_q;
  assign sample_o  = run_i && (cnt_q == SMP_AT);
  assign bit_end_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        wr_i,
  input  logic        c45_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  dev_i,
  input  logic [15:0] addr_i,
  input  logic [15:0] wdata_i,
  input  logic        sample_i,
  input  logic        bit_end_i,
  input  logic        mdio_i,
  output logic        run_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic [15:0] rdata_o,
  output logic        err_o,
  output logic        done_o
);
  localparam logic [5:0] TX_LAST_RD = 6'(RD_HDR_W - 1);
  localparam logic [5:0] TX_LAST_WR = 6'(FRAME_W - 1);
  localparam logic [5:0] RX_LAST    = 6'(DATA_W - 1);
  localparam logic [5:0] DRAIN_LAST = 6'(DRAIN_W - 1);

  mdio_state_e        state_q;
  logic [5:0]         bit_q;
  logic [FRAME_W-1:0] tx_q;
  logic [15:0]        rx_q, rdata_q;
  logic               wr_q, c45_q, second_q, ta_bad_q, err_q;
  logic [4:0]         phy_q, dev_q;
  logic [15:0]        wdata_q;
  logic               ta_eff;
  logic [1:0]         data_op;
  logic [5:0]         tx_last;

  assign data_op = c45_q ? (wr_q ? OP_C45_WR : OP_C45_RD) : (wr_q ? OP_C22_WR : OP_C22_RD);
  assign tx_last = (!wr_q && second_q) ? TX_LAST_RD : TX_LAST_WR;
  // sample and bit end may coincide when SAMPLE_DLY = HALF_DIV-1
  assign ta_eff  = (sample_i && bit_q == 6'd1) ? mdio_i : ta_bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      bit_q    <= '0;
      tx_q     <= '1;
      rx_q     <= '0;
      rdata_q  <= '0;
      wr_q     <= 1'b0;
      c45_q    <= 1'b0;
      second_q <= 1'b0;
      ta_bad_q <= 1'b0;
      err_q    <= 1'b0;
      phy_q    <= '0;
      dev_q    <= '0;
      wdata_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_i) begin
          wr_q     <= wr_i;
          c45_q    <= c45_i;
          phy_q    <= phy_i;
          dev_q    <= dev_i;
          wdata_q  <= wdata_i;
          second_q <= !c45_i;
          bit_q    <= '0;
          tx_q     <= c45_i ? mk_frame(1'b1, OP_C45_ADDR, phy_i, dev_i, addr_i)
                            : mk_frame(1'b0, wr_i ? OP_C22_WR : OP_C22_RD, phy_i, dev_i, wdata_i);
          state_q  <= S_TX;
        end
        S_TX: if (bit_end_i) begin
          tx_q <= {tx_q[FRAME_W-2:0], 1'b1};
          if (bit_q == tx_last) begin
            bit_q   <= '0;
            state_q <= (!wr_q && second_q) ? S_TA : S_TAIL;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        S_TA: begin
          if (sample_i && bit_q == 6'd1) ta_bad_q <= mdio_i;
          if (bit_end_i) begin
            if (bit_q == 6'd1) begin
              bit_q   <= '0;
              state_q <= ta_eff ? S_DRAIN : S_RX;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        S_RX: begin
          if (sample_i) rx_q <= {rx_q[14:0], mdio_i};
          if (bit_end_i) begin
            if (bit_q == RX_LAST) begin
              bit_q   <= '0;
              state_q <= S_TAIL;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        S_DRAIN: if (bit_end_i) begin
          if (bit_q == DRAIN_LAST) begin
            bit_q   <= '0;
            rdata_q <= 16'hFFFF;
            err_q   <= 1'b1;
            state_q <= S_DONE;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        S_TAIL: if (bit_end_i) begin
          if (!second_q) begin
            second_q <= 1'b1;
            tx_q     <= mk_frame(1'b1, data_op, phy_q, dev_q, wdata_q);
            state_q  <= S_TX;
          end else begin
            if (!wr_q) rdata_q <= rx_q;
            err_q   <= 1'b0;
            state_q <= S_DONE;
          end
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign run_o     = (state_q != S_IDLE) && (state_q != S_DONE);
  assign mdio_o    = tx_q[FRAME_W-1];
  assign mdio_oe_o = (state_q == S_TX);
  assign rdata_o   = rdata_q;
  assign err_o     = err_q;
  assign done_o    = (state_q == S_DONE);

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_DIV   = 16,  // 640 ns MDC period at 50 MHz
  parameter int SAMPLE_DLY = 15   // must stay below HALF_DIV
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        wr_i,
  input  logic        c45_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  dev_i,
  input  logic [15:0] addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        err_o,
  output logic        done_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic run, sample, bit_end;

  mdio_mdc_gen #(.HALF_DIV(HALF_DIV), .SAMPLE_DLY(SAMPLE_DLY)) i_mdc_gen (
    .clk_i, .rst_ni, .run_i(run), .mdc_o, .sample_o(sample), .bit_end_o(bit_end)
  );

  mdio_frame_seq i_seq (
    .clk_i, .rst_ni, .req_i, .wr_i, .c45_i, .phy_i, .dev_i, .addr_i, .wdata_i,
    .sample_i(sample), .bit_end_i(bit_end), .mdio_i,
    .run_o(run), .mdio_o, .mdio_oe_o, .rdata_o, .err_o, .done_o
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int HALF_DIV = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o,
  input logic        done_o,
  input logic        err_o,
  input logic [15:0] rdata_o
);
  logic [31:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_cnt <= '0;
    else if (mdc_o) hi_cnt <= hi_cnt + 1'b1;
    else            hi_cnt <= '0;
  end

  AST_MDC_HIGH_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mdc_o) |-> hi_cnt == 32'(HALF_DIV)); // R9
  AST_DATA_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o))); // R9
  AST_OE_MOVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_oe_o) |-> !mdc_o); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12
  AST_DONE_MDC_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!mdc_o && !mdio_oe_o)); // R1
  AST_FAIL_ALL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> rdata_o == 16'hFFFF); // R8

endmodule

bind mdio_master mdio_master_chk #(.HALF_DIV(HALF_DIV)) i_mdio_master_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mdc_o(mdc_o), .mdio_o(mdio_o),
  .mdio_oe_o(mdio_oe_o), .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  localparam int HALF = 4;
  localparam int SDLY = 2;
  localparam int TCLK = 20;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req = 1'b0, wr = 1'b0, c45 = 1'b0;
  logic [4:0]  phy = '0, dev = '0;
  logic [15:0] addr = '0, wdata = '0;
  logic [15:0] rdata;
  logic        err, done, mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_q = 1'b1;

  always #(TCLK/2) clk = ~clk;
  assign mdio_i = mdio_oe ? mdio_o : phy_q;

  mdio_master #(.HALF_DIV(HALF), .SAMPLE_DLY(SDLY)) i_mdio_master (
    .clk_i(clk), .rst_ni, .req_i(req), .wr_i(wr), .c45_i(c45), .phy_i(phy), .dev_i(dev),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .done_o(done),
    .mdc_o(mdc), .mdio_o, .mdio_oe_o(mdio_oe), .mdio_i
  );

  typedef struct { logic rd; logic [15:0] data; logic err; string tag; } exp_t;
  exp_t exp_q[$];
  int   exp_bits[$];
  int   cap_bits[$];
  int   n_chk = 0, n_fail = 0, n_done = 0;
  int   rel_k = 0, bad_per = 0;
  logic rsp_ta = 1'b0;
  logic [15:0] rsp_data = '0;
  time  last_rise = 0;
  logic prev_done = 1'b0;

  function automatic logic phy_bit(input int k);
    if (k == 0) return 1'b1;
    if (k == 1) return rsp_ta;
    if (k <= 17) return rsp_data[17-k];
    return 1'b1;
  endfunction

  // bench PHY: records each bit at MDC rise, settles read bits 30 ns later
  always @(posedge mdc) begin
    if (last_rise != 0 && ($time - last_rise) != 2*HALF*TCLK) bad_per++;
    last_rise = $time;
    if (mdio_oe) begin
      rel_k = 0;
      cap_bits.push_back(mdio_o ? 1 : 0);
    end else begin
      int k;
      k = rel_k;
      rel_k++;
      cap_bits.push_back(2);
      #30 phy_q = phy_bit(k);
    end
  end

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, expv);
    end
  endtask

  // monitor: scoreboard pop on done
  always @(negedge clk) begin
    if (rst_ni) begin
      if (done && prev_done) chk(0, "R12", "done longer than one clock", 2, 1);
      if (done) begin
        n_done++;
        if (exp_q.size() == 0) chk(0, "R11", "unexpected done", 1, 0);
        else begin
          exp_t e;
          bit same;
          e = exp_q.pop_front();
          same = (cap_bits.size() == exp_bits.size());
          if (same) foreach (exp_bits[i]) if (cap_bits[i] != exp_bits[i]) same = 0;
          chk(same, e.tag, "bus bit sequence", cap_bits.size(), exp_bits.size());
          chk(bad_per == 0, "R9", "MDC period deviations", bad_per, 0);
          chk(err == e.err, e.tag, "err flag", err, e.err);
          if (e.rd) chk(rdata == e.data, e.tag, "read data", rdata, e.data);
          cap_bits.delete(); exp_bits.delete();
          bad_per = 0; last_rise = 0;
        end
      end
      prev_done = done;
    end
  end

  task automatic push_num(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) exp_bits.push_back(v[i] ? 1 : 0);
  endtask

  task automatic push_rel(input int n);
    for (int i = 0; i < n; i++) exp_bits.push_back(2);
  endtask

  // R2..R8 frame construction from the requirements
  task automatic push_frame(input logic is45, input logic [1:0] op, input logic [4:0] p,
                            input logic [4:0] d, input logic is_rd, input logic [15:0] pay,
                            input logic ta_bad);
    push_num(16'hFFFF, 16); push_num(16'hFFFF, 16);
    push_num(is45 ? 16'd0 : 16'd1, 2);
    push_num({14'd0, op}, 2);
    push_num({11'd0, p}, 5);
    push_num({11'd0, d}, 5);
    if (is_rd) push_rel(ta_bad ? 34 : 19);
    else begin push_num(16'd2, 2); push_num(pay, 16); push_rel(1); end
  endtask

  task automatic access(input logic is45, input logic is_wr, input logic [4:0] p,
                        input logic [4:0] d, input logic [15:0] a, input logic [15:0] wd,
                        input logic ta, input logic [15:0] rd, input string tag,
                        input bit poke_busy);
    exp_t e;
    int start, guard;
    logic [1:0] op;
    if (is45) begin
      push_frame(1'b1, 2'b00, p, d, 1'b0, a, 1'b0);
      op = is_wr ? 2'b01 : 2'b11;
    end else op = is_wr ? 2'b01 : 2'b10;
    push_frame(is45, op, p, d, !is_wr, wd, ta);
    e.rd = !is_wr; e.data = ta ? 16'hFFFF : rd; e.err = !is_wr && ta; e.tag = tag;
    exp_q.push_back(e);
    rsp_ta = ta; rsp_data = rd;
    start = n_done;
    @(negedge clk);
    req = 1'b1; wr = is_wr; c45 = is45; phy = p; dev = d; addr = a; wdata = wd;
    @(negedge clk);
    req = 1'b0; wr = 1'b0; c45 = 1'b0; phy = '0; dev = '0; addr = '0; wdata = '0;
    if (poke_busy) begin
      repeat (100) @(negedge clk);
      req = 1'b1; wr = !is_wr; c45 = !is45; phy = ~p; dev = ~d; addr = ~a; wdata = ~wd;
      @(negedge clk);
      req = 1'b0;
    end
    guard = 0;
    while (n_done == start && guard < 5000) begin @(negedge clk); guard++; end
    chk(n_done != start, tag, "access completed", n_done - start, 1);
    repeat (20) @(negedge clk);
    chk(n_done == start + 1, "R11", "done count after access", n_done - start, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!mdc && !mdio_oe && !done, "R1", "outputs in reset", {mdc, mdio_oe, done}, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk(!mdc && !mdio_oe && !done, "R1", "idle after reset", {mdc, mdio_oe, done}, 0);
    // R2 R3 R4 R5 R6: Clause 45 write
    access(1'b1, 1'b1, 5'h01, 5'h1E, 16'hA5C3, 16'h3000, 1'b0, 16'h0000, "R6", 0);
    // R7 R10: Clause 45 read, good turnaround
    access(1'b1, 1'b0, 5'h1F, 5'h00, 16'h0001, 16'h0000, 1'b0, 16'h2000, "R7", 0);
    // R8: Clause 45 read, PHY silent
    access(1'b1, 1'b0, 5'h05, 5'h07, 16'hFFFF, 16'h0000, 1'b1, 16'h1234, "R8", 0);
    // R12: write after failed read clears error
    access(1'b0, 1'b1, 5'h00, 5'h1F, 16'h0000, 16'hC35A, 1'b0, 16'h0000, "R12", 0);
    // R3 R4: Clause 22 read
    access(1'b0, 1'b0, 5'h12, 5'h09, 16'h0000, 16'h0000, 1'b0, 16'h8001, "R3", 0);
    // R8: Clause 22 read, PHY silent
    access(1'b0, 1'b0, 5'h0A, 5'h15, 16'h0000, 16'h0000, 1'b1, 16'h0000, "R8", 0);
    // R10: alternating data pattern
    access(1'b1, 1'b0, 5'h15, 5'h0A, 16'h5555, 16'h0000, 1'b0, 16'hAAAA, "R10", 0);
    // R11: request while busy is ignored
    access(1'b1, 1'b0, 5'h03, 5'h01, 16'h00FF, 16'h0000, 1'b0, 16'h5A5A, "R11", 1);
    // R5: Clause 22 write, all-ones payload
    access(1'b0, 1'b1, 5'h1F, 5'h1F, 16'h0000, 16'hFFFF, 1'b0, 16'h0000, "R5", 0);
    chk(exp_q.size() == 0, "R12", "scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule